// File: doc/BRIEF.md
# Two-Phase Reduced-Complexity Parallel FIR Filter

This block is a 100-tap FIR filter that works on blocks of two samples. Each block brings an even-phase sample and the odd-phase sample that follows it. Each block gives back the two matching filter outputs. The filter splits into an even-coefficient half and an odd-coefficient half.

Only three multiply-accumulate lanes are used instead of four. The first lane convolves the even coefficients with the even samples. The second convolves the odd coefficients with the odd samples. The third convolves the pairwise coefficient sums with the pairwise sample sums. The cross terms then come from a subtraction. A register carries the odd-lane result into the next block to supply the one-block delay that the even output needs.

Each lane has its own 50-entry sample history and walks it one tap per cycle against a synchronous coefficient table. A block is accepted only while the filter is idle. One result pair appears 52 cycles later. Data and coefficients are signed fixed point with 15 fraction bits.

Top module: `fir_pair_rc`

## Requirements
- R1: After reset, valid_o is 0 and y0_o and y1_o are 0. All sample history reads as zero, so the first block is filtered as if every earlier sample were zero.
- R2: Coefficient i, for i from 0 to 99, is h[i] = (((37*i + 11) mod 251) - 125) * 97, held as a signed 16-bit value.
- R3: The samples form one stream in which block k places x0_i at index 2k and x1_i at index 2k+1. For block k, y0_o equals bits [30:15] of the exact sum of h[i]*x[2k-i] over all i.
- R4: For block k, y1_o equals bits [30:15] of the exact sum of h[i]*x[2k+1-i] over all i.
- R5: Samples from earlier blocks keep contributing to later outputs across block boundaries. This includes the one-block-delayed odd-lane term in y0_o.
- R6: valid_o goes high for exactly one cycle, on the 52nd rising edge after the edge that accepted the block. It stays low at every edge in between.
- R7: valid_i is acted on only while the filter is idle. Any strobe during the computation is ignored. This includes a strobe on the very edge that raises valid_o. The earliest next acceptance is the edge after valid_o rises.
- R8: Between valid_o pulses, y0_o and y1_o hold their last values.
- R9: Full-scale inputs of +32767 or -32768 on every sample do not overflow the accumulators. The results still follow R3 and R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Block strobe; sampled only while idle |
| x0_i | input | 16 | Earlier (even-index) sample of the block |
| x1_i | input | 16 | Later (odd-index) sample of the block |
| valid_o | output | 1 | One-cycle pulse marking a new result pair |
| y0_o | output | 16 | Even-index filter output |
| y1_o | output | 16 | Odd-index filter output |

## Verification
Two events can land on the same edge: the result pair is registered and the block-delay register is updated, and a new valid_i strobe arrives. The bench provokes this in noisy blocks by holding valid_i high with random data on every cycle of the computation, including the final one.

It then judges the outcome two ways. The pulse must land exactly 52 edges after acceptance. The following block's outputs must match a convolution over only the intended samples, so any absorbed strobe would show up as a wrong value. Back-to-back blocks, driven in the cycle right after the pulse, confirm that acceptance resumes at once.

// File: rtl/fir_pair_pkg.sv
package fir_pair_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_MAC = 2'd1, ST_DONE = 2'd2} fsm_e;

  // Fixed coefficient set, computed rather than tabulated
  function automatic int coef_at(int i);
    return (((i * 37 + 11) % 251) - 125) * 97;
  endfunction
endpackage

// File: rtl/fir_pair_coef_rom.sv
module fir_pair_coef_rom #(
  parameter int N  = 100,
  parameter int W  = 16,
  parameter int AW = 7
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_en_i,
  input  logic [AW-1:0]       addr_a_i,
  input  logic [AW-1:0]       addr_b_i,
  output logic signed [W-1:0] q_a_o,
  output logic signed [W-1:0] q_b_o
);
  logic signed [W-1:0] rom [N];

  for (genvar g = 0; g < N; g++) begin : g_rom
    assign rom[g] = W'(fir_pair_pkg::coef_at(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_a_o <= '0;
      q_b_o <= '0;
    end else if (rd_en_i) begin
      q_a_o <= rom[addr_a_i];
      q_b_o <= rom[addr_b_i];
    end
  end
endmodule

// File: rtl/fir_pair_tap_line.sv
module fir_pair_tap_line #(
  parameter int DEPTH = 50,
  parameter int W     = 16,
  parameter int IW    = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_i,
  input  logic signed [W-1:0] din_i,
  input  logic                rd_en_i,
  input  logic [IW-1:0]       idx_i,
  output logic signed [W-1:0] q_o,
  output logic signed [W-1:0] head_o
);
  logic signed [W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tap
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      mem[g] <= '0;
        else if (shift_i) mem[g] <= din_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      mem[g] <= '0;
        else if (shift_i) mem[g] <= mem[g-1];
      end
    end
  end

  assign head_o = mem[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (rd_en_i) q_o <= mem[idx_i];
  end
endmodule

// File: rtl/fir_pair_mac.sv
module fir_pair_mac #(
  parameter int A_W   = 16,
  parameter int B_W   = 16,
  parameter int ACC_W = 40
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    en_i,
  input  logic signed [A_W-1:0]   a_i,
  input  logic signed [B_W-1:0]   b_i,
  output logic signed [ACC_W-1:0] acc_o
);
  logic signed [A_W+B_W-1:0] prod;
  assign prod = a_i * b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_o <= '0;
    else if (clr_i) acc_o <= '0;
    else if (en_i)  acc_o <= acc_o + ACC_W'(prod);
  end
endmodule

// File: rtl/fir_pair_rc.sv
module fir_pair_rc #(
  parameter int NUM_TAPS = 100,
  parameter int DATA_W   = 16,
  parameter int COEF_W   = 16,
  parameter int ACC_W    = 40
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic signed [DATA_W-1:0] x0_i,
  input  logic signed [DATA_W-1:0] x1_i,
  output logic                     valid_o,
  output logic signed [DATA_W-1:0] y0_o,
  output logic signed [DATA_W-1:0] y1_o
);
  import fir_pair_pkg::*;

  localparam int SUB    = NUM_TAPS / 2;
  localparam int IDX_W  = $clog2(SUB);
  localparam int CNT_W  = $clog2(SUB + 1);
  localparam int ADDR_W = IDX_W + 1;
  localparam int SHIFT  = COEF_W - 1;
  localparam int SUM_W  = ACC_W + 2;

  fsm_e             state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept, rd_en, mac_en;

  assign accept = (state_q == ST_IDLE) && valid_i;
  assign rd_en  = (state_q == ST_MAC) && (cnt_q < CNT_W'(SUB));
  assign mac_en = (state_q == ST_MAC) && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (valid_i) begin
          state_q <= ST_MAC;
          cnt_q   <= '0;
        end
        ST_MAC: begin
          if (cnt_q == CNT_W'(SUB)) state_q <= ST_DONE;
          else                      cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Pre-addition of the pair, one bit wider
  logic signed [DATA_W:0] xsum;
  assign xsum = {x0_i[DATA_W-1], x0_i} + {x1_i[DATA_W-1], x1_i};

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] addr_e, addr_o;
  assign idx    = cnt_q[IDX_W-1:0];
  assign addr_e = {idx, 1'b0};
  assign addr_o = {idx, 1'b1};

  logic signed [COEF_W-1:0] h_e, h_o;
  logic signed [COEF_W:0]   h_s;

  fir_pair_coef_rom #(.N(NUM_TAPS), .W(COEF_W), .AW(ADDR_W)) u_rom (
    .clk_i(clk_i), .rst_ni(rst_ni), .rd_en_i(rd_en),
    .addr_a_i(addr_e), .addr_b_i(addr_o), .q_a_o(h_e), .q_b_o(h_o)
  );

  assign h_s = {h_e[COEF_W-1], h_e} + {h_o[COEF_W-1], h_o};

  logic signed [DATA_W-1:0] d0, d1, hd0, hd1;
  logic signed [DATA_W:0]   d2, hd2;

  fir_pair_tap_line #(.DEPTH(SUB), .W(DATA_W), .IW(IDX_W)) u_line0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(accept), .din_i(x0_i),
    .rd_en_i(rd_en), .idx_i(idx), .q_o(d0), .head_o(hd0)
  );
  fir_pair_tap_line #(.DEPTH(SUB), .W(DATA_W), .IW(IDX_W)) u_line1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(accept), .din_i(x1_i),
    .rd_en_i(rd_en), .idx_i(idx), .q_o(d1), .head_o(hd1)
  );
  fir_pair_tap_line #(.DEPTH(SUB), .W(DATA_W + 1), .IW(IDX_W)) u_line2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(accept), .din_i(xsum),
    .rd_en_i(rd_en), .idx_i(idx), .q_o(d2), .head_o(hd2)
  );

  logic signed [ACC_W-1:0] acc0, acc1, acc2, f1_prev_q;

  fir_pair_mac #(.A_W(DATA_W), .B_W(COEF_W), .ACC_W(ACC_W)) u_mac0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept), .en_i(mac_en),
    .a_i(d0), .b_i(h_e), .acc_o(acc0)
  );
  fir_pair_mac #(.A_W(DATA_W), .B_W(COEF_W), .ACC_W(ACC_W)) u_mac1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept), .en_i(mac_en),
    .a_i(d1), .b_i(h_o), .acc_o(acc1)
  );
  fir_pair_mac #(.A_W(DATA_W + 1), .B_W(COEF_W + 1), .ACC_W(ACC_W)) u_mac2 (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(accept), .en_i(mac_en),
    .a_i(d2), .b_i(h_s), .acc_o(acc2)
  );

  // Post-combination
  logic signed [SUM_W-1:0] y0_full, y1_full;
  assign y0_full = SUM_W'(acc0) + SUM_W'(f1_prev_q);
  assign y1_full = SUM_W'(acc2) - SUM_W'(acc0) - SUM_W'(acc1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      y0_o      <= '0;
      y1_o      <= '0;
      f1_prev_q <= '0;
    end else begin
      valid_o <= (state_q == ST_DONE);
      if (state_q == ST_DONE) begin
        y0_o      <= y0_full[SHIFT +: DATA_W];
        y1_o      <= y1_full[SHIFT +: DATA_W];
        f1_prev_q <= acc1;
      end
    end
  end
endmodule

// File: rtl/fir_pair_rc_chk.sv
module fir_pair_rc_chk #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40,
  parameter int CNT_W  = 6,
  parameter int SUB    = 50
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     valid_o,
  input logic signed [DATA_W-1:0] y0_o,
  input logic signed [DATA_W-1:0] y1_o,
  input logic [1:0]               state_i,
  input logic [CNT_W-1:0]         cnt_i,
  input logic signed [DATA_W-1:0] hd0_i,
  input logic signed [DATA_W-1:0] hd1_i,
  input logic signed [DATA_W:0]   hd2_i,
  input logic signed [ACC_W-1:0]  acc1_i,
  input logic signed [ACC_W-1:0]  f1_prev_i
);
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);  // R6

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(SUB));  // R6

  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != 2'd0) |=> ($stable(hd0_i) && $stable(hd1_i) && $stable(hd2_i)));  // R7

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(y0_o) && $stable(y1_o)));  // R8

  AST_BLOCK_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (f1_prev_i == $past(acc1_i)));  // R5
endmodule

bind fir_pair_rc fir_pair_rc_chk #(
  .DATA_W(DATA_W), .ACC_W(ACC_W), .CNT_W(CNT_W), .SUB(SUB)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_o(valid_o), .y0_o(y0_o), .y1_o(y1_o),
  .state_i(state_q), .cnt_i(cnt_q), .hd0_i(hd0), .hd1_i(hd1), .hd2_i(hd2),
  .acc1_i(acc1), .f1_prev_i(f1_prev_q)
);

// File: tb/fir_pair_rc_bench.sv
module fir_pair_rc_bench;
  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               valid_i = 1'b0;
  logic signed [15:0] x0_i = '0, x1_i = '0;
  logic               valid_o;
  logic signed [15:0] y0_o, y1_o;

  int errors = 0;
  int checks = 0;
  int hist [0:1023];
  int nsamp = 0;

  always #5 clk_i = ~clk_i;

  fir_pair_rc u_fir_pair_rc (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .x0_i(x0_i), .x1_i(x1_i),
    .valid_o(valid_o), .y0_o(y0_o), .y1_o(y1_o)
  );

  // R2 coefficient formula
  function automatic longint h_ref(int i);
    return longint'((((37 * i + 11) % 251) - 125) * 97);
  endfunction

  function automatic logic [15:0] y_ref(int n);
    longint s = 0;
    for (int i = 0; i < 100; i++)
      if (n - i >= 0) s += h_ref(i) * longint'(hist[n - i]);
    return 16'(s >>> 15);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_block(int a0, int a1, bit noisy, string tag);
    logic [15:0] e0, e1;
    bit early = 0;
    hist[nsamp] = a0;
    hist[nsamp + 1] = a1;
    nsamp += 2;
    e0 = y_ref(nsamp - 2);
    e1 = y_ref(nsamp - 1);
    valid_i = 1'b1;
    x0_i = 16'(a0);
    x1_i = 16'(a1);
    @(posedge clk_i); @(negedge clk_i);
    for (int c = 1; c <= 52; c++) begin
      if (noisy) begin
        valid_i = 1'b1;                 // R7 strobes while busy, incl. the output edge
        x0_i = 16'($urandom);
        x1_i = 16'($urandom);
      end else begin
        valid_i = 1'b0;
      end
      @(posedge clk_i); @(negedge clk_i);
      if (c < 52 && valid_o) early = 1;
    end
    valid_i = 1'b0;
    check("R6 no early valid", 16'(early), 16'(0));
    check("R6 valid at edge 52", 16'(valid_o), 16'(1));
    check({tag, " R3 y0"}, y0_o, e0);
    check({tag, " R4 y1"}, y1_o, e1);
  endtask

  task automatic idle_gap(int n);
    logic [15:0] h0, h1;
    h0 = y0_o;
    h1 = y1_o;
    valid_i = 1'b0;
    for (int c = 0; c < n; c++) begin
      x0_i = 16'($urandom);
      x1_i = 16'($urandom);
      @(posedge clk_i); @(negedge clk_i);
      check("R6 pulse ends", 16'(valid_o), 16'(0));
      check("R8 y0 hold", y0_o, h0);
      check("R8 y1 hold", y1_o, h1);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk_i);
    check("R1 valid_o", 16'(valid_o), 16'(0));
    check("R1 y0", y0_o, 16'(0));
    check("R1 y1", y1_o, 16'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 valid_o after release", 16'(valid_o), 16'(0));

    // Impulse, then zeros: coefficients emerge across blocks (R1, R2, R5)
    send_block(16384, 0, 1'b0, "R1 R2");
    idle_gap(2);
    for (int b = 0; b < 6; b++) send_block(0, 0, 1'b0, "R5");
    send_block(0, -16384, 1'b1, "R2");
    for (int b = 0; b < 4; b++) send_block(0, 0, b[0], "R5");

    // Full-scale runs, back to back, strobes held high (R9, R7)
    for (int b = 0; b < 52; b++) send_block(32767, 32767, b[0], "R9");
    for (int b = 0; b < 52; b++) send_block(-32768, -32768, ~b[0], "R9");
    for (int b = 0; b < 4; b++) send_block(32767, -32768, 1'b1, "R9");

    // Random blocks with random gaps and noise
    for (int b = 0; b < 40; b++) begin
      send_block(int'($signed(16'($urandom))), int'($signed(16'($urandom))),
                 1'($urandom), "R5");
      if ($urandom % 3 == 0) idle_gap(1 + int'($urandom % 4));
    end
    idle_gap(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule